// File: doc/BRIEF.md
# Multidrop Address-Wake Serial Channel

This block is one serial channel with nine-bit multidrop framing. A flag bit tells address characters from data characters. The transmitter inserts a programmable address/data flag bit straight after the last data bit of each character. The receiver recovers that flag. Comparing a received address with the station's own address is a software task, and so is generating the baud rate. The block takes a strobe at sixteen times the bit rate from outside.

While its receiver is disabled, a station still watches the line. Only characters whose flag bit is one (address characters) enter its receive queue, and they raise the ready indication and, if enabled, the interrupt. Software reads the address, decides whether the station is addressed, and enables the receiver to take the data block that follows. While the receiver is enabled, every character is queued together with its received flag bit. Eight data bits give room for 256 station addresses. With the multidrop mode off, the channel sends and receives plain characters with no flag bit.

Top module: `mdrop_uart`

## Requirements
- R1: After reset the serial output is high, and tx_busy, rx_rdy, overrun and irq are all low. The serial output is high whenever the transmitter is idle.
- R2: With mode_cfg[4:3] = 2'b11 (multidrop), a loaded character goes out as a low start bit, then the data bits LSB first, then the flag bit, then the stop bits (high), each lasting 16 os_tick strobes.
- R3: The transmitted flag bit is the value of mode_cfg[2] when tx_load is accepted. Changing mode_cfg[2] while the character is in flight does not alter it.
- R4: mode_cfg[1:0] selects the data length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits) for both directions. stop_two = 1 sends two stop bits instead of one.
- R5: With mode_cfg[4:3] other than 2'b11, no flag bit is sent: the first stop bit follows the last data bit directly.
- R6: In multidrop mode with rx_enable low, a received character with flag 1 is queued and shown with rx_addr_flag = 1. A character with flag 0 is discarded and leaves rx_rdy low.
- R7: In multidrop mode with rx_enable high, every received character is queued, and its flag bit appears on rx_addr_flag.
- R8: Outside multidrop mode, a disabled receiver queues nothing. An enabled receiver queues every character with rx_addr_flag = 0.
- R9: A character that would be queued while the queue is full is dropped, and the sticky overrun output goes high until reset. The queued characters stay unchanged.
- R10: irq is high exactly when irq_enable is high and rx_rdy is high.
- R11: The queue gives characters back in arrival order. rx_rdy stays high until the last one is removed with rx_pop, and rx_data and rx_addr_flag show the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Strobe at 16 times the bit rate |
| mode_cfg | input | 5 | [4:3] mode (11 = multidrop), [2] flag value to send, [1:0] data length code |
| stop_two | input | 1 | Two stop bits when high |
| rx_enable | input | 1 | Receiver enable |
| irq_enable | input | 1 | Interrupt enable |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Load tx_data when the transmitter is idle |
| tx_busy | output | 1 | Transmitter is sending a character |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input |
| rx_pop | input | 1 | Remove the oldest queued character |
| rx_rdy | output | 1 | Queue holds at least one character |
| rx_data | output | 8 | Oldest queued character, right-aligned |
| rx_addr_flag | output | 1 | Flag bit of the oldest queued character |
| overrun | output | 1 | Sticky overrun indication |
| irq | output | 1 | Interrupt request |

## Verification
The receive path sees address and data characters with the receiver disabled and then enabled. This shows whether the wake filter depends on the flag and on the enable, and not on the character value. The same characters in plain mode show that the filter is tied to the multidrop mode alone. On transmit, 8-bit and 5-bit lengths, one and two stop bits, and both flag values show where the flag bit sits and that it is latched at load. A burst of address characters into a full queue shows that nothing is written past the limit and that the earlier characters come back intact and in order.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int unsigned CHAR_W  = 8;
  localparam int unsigned FRAME_W = 12;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_FLAG, RX_STOP
  } rx_state_t;

  function automatic int unsigned data_len(input logic [1:0] code);
    return 5 + int'(code);
  endfunction
endpackage

// File: rtl/mdrop_tx.sv
module mdrop_tx
  import mdrop_pkg::*;
#(
  parameter int unsigned OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              load,
  input  logic [CHAR_W-1:0] data,
  input  logic [1:0]        len_code,
  input  logic              md_on,
  input  logic              flag_val,
  input  logic              two_stop,
  output logic              busy,
  output logic              line
);
  localparam int unsigned CW = $clog2(OS_RATE);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [3:0]         total;
  logic [CW-1:0]      cnt;

  always_comb begin
    int unsigned n;
    n = data_len(len_code);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < int'(CHAR_W); i++)
      if (i < int'(n)) frame[1+i] = data[i];
    if (md_on) frame[1+n] = flag_val;
    total = 4'(1 + n + (md_on ? 1 : 0) + 1 + (two_stop ? 1 : 0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      line  <= 1'b1;
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
    end else if (!busy) begin
      if (load) begin
        busy  <= 1'b1;
        line  <= frame[0];
        shreg <= {1'b1, frame[FRAME_W-1:1]};
        left  <= total - 4'd1;
        cnt   <= '0;
      end
    end else if (os_tick) begin
      if (cnt == CW'(OS_RATE-1)) begin
        cnt <= '0;
        if (left == 4'd0) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          line  <= shreg[0];
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - 4'd1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int unsigned OS_RATE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            os_tick,
  input  logic            line,
  input  logic [1:0]      len_code,
  input  logic            md_on,
  input  logic            rx_en,
  input  logic            q_full,
  output logic            push,
  output logic            ovr_set,
  output logic [CHAR_W:0] word
);
  localparam int unsigned CW = $clog2(OS_RATE);

  rx_state_t         st;
  logic              s1, s2;
  logic [CW-1:0]     cnt;
  logic [3:0]        bidx;
  logic [CHAR_W-1:0] sh;
  logic              flag;
  logic [3:0]        nbits;
  logic              at_mid;
  logic              accept;
  logic              done;

  assign nbits  = 4'(data_len(len_code));
  assign at_mid = os_tick && (cnt == CW'(OS_RATE-1));
  assign accept = rx_en || (md_on && flag);
  assign done   = (st == RX_STOP) && at_mid;
  assign push    = done && accept && !q_full;
  assign ovr_set = done && accept && q_full;
  assign word    = {flag, sh >> (4'd8 - nbits)};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bidx <= '0;
      sh   <= '0;
      flag <= 1'b0;
    end else if (os_tick) begin
      case (st)
        RX_IDLE: if (!s2) begin
          st   <= RX_START;
          cnt  <= '0;
          flag <= 1'b0;
          bidx <= '0;
        end
        RX_START: begin
          if (cnt == CW'(OS_RATE/2-1)) begin
            cnt <= '0;
            st  <= s2 ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (at_mid) begin
            cnt  <= '0;
            sh   <= {s2, sh[CHAR_W-1:1]};
            bidx <= bidx + 4'd1;
            if (bidx == nbits - 4'd1) st <= md_on ? RX_FLAG : RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_FLAG: begin
          if (at_mid) begin
            cnt  <= '0;
            flag <= s2;
            st   <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        RX_STOP: begin
          if (at_mid) begin
            cnt <= '0;
            st  <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_fifo.sv
module mdrop_fifo #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             nonempty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      fill;
  logic             do_wr, do_rd;

  assign full     = (fill == (AW+1)'(DEPTH));
  assign nonempty = (fill != '0);
  assign do_wr    = wr && !full;
  assign do_rd    = rd && nonempty;
  assign rdata    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdrop_pkg::*;
#(
  parameter int unsigned OS_RATE    = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic [4:0]        mode_cfg,
  input  logic              stop_two,
  input  logic              rx_enable,
  input  logic              irq_enable,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_busy,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_pop,
  output logic              rx_rdy,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_addr_flag,
  output logic              overrun,
  output logic              irq
);
  logic            md_on;
  logic            push, ovr_set, q_full;
  logic [CHAR_W:0] rx_word, q_out;

  assign md_on = (mode_cfg[4:3] == 2'b11);

  mdrop_tx #(.OS_RATE(OS_RATE)) u_tx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .load(tx_load), .data(tx_data),
    .len_code(mode_cfg[1:0]), .md_on(md_on), .flag_val(mode_cfg[2]),
    .two_stop(stop_two), .busy(tx_busy), .line(tx_line)
  );

  mdrop_rx #(.OS_RATE(OS_RATE)) u_rx (
    .clk(clk), .rst(rst), .os_tick(os_tick), .line(rx_line),
    .len_code(mode_cfg[1:0]), .md_on(md_on), .rx_en(rx_enable),
    .q_full(q_full), .push(push), .ovr_set(ovr_set), .word(rx_word)
  );

  mdrop_fifo #(.WIDTH(CHAR_W+1), .DEPTH(FIFO_DEPTH)) u_q (
    .clk(clk), .rst(rst), .wr(push), .wdata(rx_word), .rd(rx_pop),
    .rdata(q_out), .full(q_full), .nonempty(rx_rdy)
  );

  assign rx_data      = q_out[CHAR_W-1:0];
  assign rx_addr_flag = q_out[CHAR_W];
  assign irq          = irq_enable && rx_rdy;

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (ovr_set) overrun <= 1'b1;
  end
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
  input logic       clk,
  input logic       rst,
  input logic       os_tick,
  input logic [4:0] mode_cfg,
  input logic       stop_two,
  input logic       rx_enable,
  input logic       irq_enable,
  input logic [7:0] tx_data,
  input logic       tx_load,
  input logic       tx_busy,
  input logic       tx_line,
  input logic       rx_line,
  input logic       rx_pop,
  input logic       rx_rdy,
  input logic [7:0] rx_data,
  input logic       rx_addr_flag,
  input logic       overrun,
  input logic       irq
);
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_line);
  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !tx_busy) |=> (tx_busy && !tx_line));
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  p_ovr_full_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> rx_rdy);
  p_rdy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_rdy && !rx_pop) |=> rx_rdy);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_enable |-> !irq);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (.*);

// File: tb/sim_mdrop_uart.sv
module sim_mdrop_uart;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic [4:0] mode_cfg = '0;
  logic       stop_two = 1'b0;
  logic       rx_enable = 1'b0;
  logic       irq_enable = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_load = 1'b0;
  logic       tx_busy, tx_line;
  logic       rx_line = 1'b1;
  logic       rx_pop = 1'b0;
  logic       rx_rdy, rx_addr_flag, overrun, irq;
  logic [7:0] rx_data;
  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  mdrop_uart u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_case(input string tag, input logic [7:0] d, input logic [1:0] code,
                         input logic md, input logic ad, input logic two, input logic flip);
    int n = 5 + int'(code);
    @(negedge clk);
    mode_cfg = {md ? 2'b11 : 2'b00, ad, code};
    stop_two = two;
    tx_data  = d;
    tx_load  = 1'b1;
    @(posedge clk);
    #1 tx_load = 1'b0;
    if (flip) mode_cfg[2] = ~ad;
    repeat (8) @(posedge clk);
    #1 chk({tag, " start bit"}, int'(tx_line), 0);
    for (int i = 0; i < n; i++) begin
      repeat (16) @(posedge clk);
      #1 chk({tag, " data bit"}, int'(tx_line), int'(d[i]));
    end
    if (md) begin
      repeat (16) @(posedge clk);
      #1 chk({tag, " flag bit"}, int'(tx_line), int'(ad));
    end
    for (int s = 0; s < (two ? 2 : 1); s++) begin
      repeat (16) @(posedge clk);
      #1 chk({tag, " stop bit"}, int'(tx_line), 1);
    end
    repeat (16) @(posedge clk);
    #1 chk({tag, " idle after frame"}, int'(tx_busy), 0);
  endtask

  task automatic send_rx(input logic [7:0] d, input int n, input logic md, input logic ad);
    @(negedge clk) rx_line = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_line = d[i];
      repeat (16) @(negedge clk);
    end
    if (md) begin
      rx_line = ad;
      repeat (16) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (22) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk) rx_pop = 1'b1;
    @(negedge clk) rx_pop = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 line high", int'(tx_line), 1);
    chk("R1 busy", int'(tx_busy), 0);
    chk("R1 rdy", int'(rx_rdy), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_tx();
    tx_case("R2 md 8b flag1", 8'hC5, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    tx_case("R3 R4 md 5b flag0 flipped 2stop", 8'h16, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
    tx_case("R5 plain 7b", 8'h55, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_rx_wake();
    @(negedge clk);
    mode_cfg = 5'b11011; rx_enable = 1'b0; irq_enable = 1'b1;
    send_rx(8'h3C, 8, 1'b1, 1'b0);
    chk("R6 data char dropped", int'(rx_rdy), 0);
    chk("R10 no irq when empty", int'(irq), 0);
    send_rx(8'hA5, 8, 1'b1, 1'b1);
    chk("R6 address queued", int'(rx_rdy), 1);
    chk("R6 address value", int'(rx_data), 'hA5);
    chk("R6 address flag", int'(rx_addr_flag), 1);
    chk("R10 irq raised", int'(irq), 1);
    @(negedge clk) irq_enable = 1'b0;
    #1 chk("R10 irq masked", int'(irq), 0);
    pop_one();
    chk("R11 empty after pop", int'(rx_rdy), 0);
  endtask

  task automatic t_rx_enabled();
    @(negedge clk);
    mode_cfg = 5'b11011; rx_enable = 1'b1;
    send_rx(8'h3C, 8, 1'b1, 1'b0);
    send_rx(8'h5A, 8, 1'b1, 1'b1);
    chk("R7 first value", int'(rx_data), 'h3C);
    chk("R7 first flag", int'(rx_addr_flag), 0);
    pop_one();
    chk("R11 second value", int'(rx_data), 'h5A);
    chk("R7 second flag", int'(rx_addr_flag), 1);
    pop_one();
    chk("R11 drained", int'(rx_rdy), 0);
  endtask

  task automatic t_rx_plain();
    @(negedge clk);
    mode_cfg = 5'b00001; rx_enable = 1'b0;
    send_rx(8'h2B, 6, 1'b0, 1'b0);
    chk("R8 disabled plain dropped", int'(rx_rdy), 0);
    @(negedge clk) rx_enable = 1'b1;
    send_rx(8'h2B, 6, 1'b0, 1'b0);
    chk("R8 enabled plain queued", int'(rx_rdy), 1);
    chk("R4 6-bit value", int'(rx_data), 'h2B);
    chk("R8 flag zero", int'(rx_addr_flag), 0);
    pop_one();
  endtask

  task automatic t_overrun();
    @(negedge clk);
    mode_cfg = 5'b11011; rx_enable = 1'b0;
    for (int k = 0; k < 5; k++) send_rx(8'(8'h10 + k), 8, 1'b1, 1'b1);
    chk("R9 overrun set", int'(overrun), 1);
    for (int k = 0; k < 4; k++) begin
      chk("R9 kept entry", int'(rx_data), 'h10 + k);
      pop_one();
    end
    chk("R9 nothing extra", int'(rx_rdy), 0);
    chk("R9 overrun sticky", int'(overrun), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_tx();
    t_rx_wake();
    t_rx_enabled();
    t_rx_plain();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule